// File: doc/BRIEF.md
# Command Queue Scan Status Tracker

This block follows the scan state of a single command queue inside an ADC command-FIFO controller and publishes it as a 2-bit status code. The queue's operating mode, a software-set start flag, an asynchronous external trigger, a pause request and an end-of-queue pulse from the command transfer engine together decide whether the queue is idle, armed and waiting for a trigger, or triggered and feeding commands.

Single-scan modes run the queue once per software start. Continuous-scan modes re-arm after every pass. The trigger input is synchronised inside the block and then used either as a rising edge or as a level, depending on the mode. When a single scan finishes, the block sends a one-cycle clear to the start flag. It then ignores that flag until software has actually dropped it.

All outputs are registered. Reset is synchronous and active high.

Top module: `cq_scan_status`

## Requirements
- R1: The status output only ever takes the values 2'b00 (idle), 2'b10 (waiting for trigger) or 2'b11 (triggered). The value 2'b01 never appears.
- R2: Mode codes are: 0 off, 1 single-scan software, 2 single-scan edge, 3 single-scan level, 4 continuous-scan edge and 5 continuous-scan level. Codes 6 and 7 behave as off. While reset is held, and on the edge after any cycle with an off mode, the status is idle and both pulse outputs are low.
- R3: In modes 2 and 3 the status stays idle while the effective start flag is low. It moves to waiting once the flag is seen high. Entering one of these modes with the flag high gives waiting, and entering with it low gives idle. These modes never go directly from idle to triggered.
- R4: Entering mode 1 always gives waiting. In mode 1 the start flag acts as the trigger: from waiting or idle, a high effective flag with no pause gives triggered. From idle, a high flag together with a pause gives waiting.
- R5: Entering mode 4 or mode 5 gives waiting.
- R6: Edge modes (2 and 4) trigger on a rising edge of the trigger input after a two-flop synchroniser. The status shows triggered on the third clock edge after the input rises. An input that is held high does not trigger again.
- R7: Level modes (3 and 5) go from waiting to triggered while the synchronised input is high. They return from triggered to waiting when it is low.
- R8: A pause request moves triggered to waiting. While the request is held, no trigger is accepted. A pause has no effect on idle.
- R9: In modes 1 to 3, an end-of-queue pulse while triggered gives idle and a one-cycle start-clear pulse in the same cycle. From that pulse until the start flag is seen low, the start flag is ignored.
- R10: In mode 4, an end-of-queue pulse while triggered gives waiting. In mode 5 it has no effect, and the level rule applies.
- R11: A mode change takes effect on the next edge and overrides trigger, pause and end-of-queue in the same cycle. In a single-scan mode, end-of-queue overrides pause.
- R12: The triggered output is high exactly when the status is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Queue operating mode (codes in R2) |
| start_flag | input | 1 | Single-scan start flag set by software |
| trig_in | input | 1 | Asynchronous external trigger |
| pause_req | input | 1 | Pause request |
| last_done | input | 1 | Last queue entry transferred, one-cycle pulse |
| status | output | 2 | Scan status code |
| triggered | output | 1 | Queue is triggered, to the transfer engine |
| start_clr | output | 1 | One-cycle clear for the start flag |

## Verification
The assertions check the following on every cycle:
- the reserved code never appears;
- an off mode always leads to idle;
- single-scan edge and level modes never jump from idle to triggered;
- a pause always knocks a triggered queue back to waiting;
- end-of-queue gives the correct return state in single-scan and continuous-edge modes;
- the start-clear pulse lasts one cycle and only comes with idle;
- the triggered output matches the status.

Other behaviour can only be shown by the bench's scenarios, which compare the outputs against a behavioural model on every clock. These are the three-edge trigger latency through the synchroniser, the absence of a re-trigger on a held-high input, the blocking of the start flag until software drops it, and the priority of a mode change over coincident events.

// File: rtl/cqs_pkg.sv
package cqs_pkg;

  localparam int MODE_W = 3;
  localparam int STAT_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF     = 3'd0,
    MODE_SS_SW   = 3'd1,
    MODE_SS_EDGE = 3'd2,
    MODE_SS_LVL  = 3'd3,
    MODE_CS_EDGE = 3'd4,
    MODE_CS_LVL  = 3'd5
  } cq_mode_e;

  typedef enum logic [STAT_W-1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b10,
    ST_TRIG = 2'b11
  } cq_stat_e;

  typedef struct packed {
    logic off;
    logic single;
    logic sw;
    logic edge_t;
    logic lvl_t;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] m);
    mode_dec_t d;
    d = '0;
    case (m)
      MODE_SS_SW:   begin d.single = 1'b1; d.sw = 1'b1; end
      MODE_SS_EDGE: begin d.single = 1'b1; d.edge_t = 1'b1; end
      MODE_SS_LVL:  begin d.single = 1'b1; d.lvl_t = 1'b1; end
      MODE_CS_EDGE: d.edge_t = 1'b1;
      MODE_CS_LVL:  d.lvl_t = 1'b1;
      default:      d.off = 1'b1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cqs_trig_sync.sv
module cqs_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/cqs_start_guard.sv
module cqs_start_guard (
  input  logic clk,
  input  logic rst,
  input  logic start_flag,
  input  logic clr_pulse,
  output logic flag_eff
);

  // Once a clear has been issued, hold the flag off until it is seen low.
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)            pend_q <= 1'b0;
    else if (clr_pulse) pend_q <= 1'b1;
    else if (!start_flag) pend_q <= 1'b0;
  end

  assign flag_eff = start_flag & ~pend_q & ~clr_pulse;

endmodule

// File: rtl/cqs_status_fsm.sv
module cqs_status_fsm
  import cqs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              flag_eff,
  input  logic              trig_lvl,
  input  logic              trig_rise,
  input  logic              pause_req,
  input  logic              last_done,
  output logic [STAT_W-1:0] status,
  output logic              triggered,
  output logic              start_clr
);

  cq_stat_e          stat_q, stat_n;
  logic [MODE_W-1:0] mode_q;
  logic              clr_n;
  logic              trig_hit;
  mode_dec_t         dec;

  always_comb begin
    dec      = decode_mode(mode);
    trig_hit = (dec.sw & flag_eff) | (dec.edge_t & trig_rise) | (dec.lvl_t & trig_lvl);
    stat_n   = stat_q;
    clr_n    = 1'b0;
    if (dec.off) begin
      stat_n = ST_IDLE;
    end else if (mode != mode_q) begin
      if (dec.single && !dec.sw) stat_n = flag_eff ? ST_WAIT : ST_IDLE;
      else                       stat_n = ST_WAIT;
    end else begin
      case (stat_q)
        ST_IDLE: begin
          if (dec.single && flag_eff)
            stat_n = (dec.sw && !pause_req) ? ST_TRIG : ST_WAIT;
        end
        ST_WAIT: begin
          if (!pause_req && trig_hit) stat_n = ST_TRIG;
        end
        ST_TRIG: begin
          if (last_done && dec.single) begin
            stat_n = ST_IDLE;
            clr_n  = 1'b1;
          end else if (last_done && dec.edge_t) begin
            stat_n = ST_WAIT;
          end else if (pause_req) begin
            stat_n = ST_WAIT;
          end else if (dec.lvl_t && !trig_lvl) begin
            stat_n = ST_WAIT;
          end
        end
        default: stat_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= ST_IDLE;
      mode_q    <= MODE_OFF;
      triggered <= 1'b0;
      start_clr <= 1'b0;
    end else begin
      stat_q    <= stat_n;
      mode_q    <= mode;
      triggered <= (stat_n == ST_TRIG);
      start_clr <= clr_n;
    end
  end

  assign status = stat_q;

endmodule

// File: rtl/cq_scan_status.sv
module cq_scan_status
  import cqs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              start_flag,
  input  logic              trig_in,
  input  logic              pause_req,
  input  logic              last_done,
  output logic [STAT_W-1:0] status,
  output logic              triggered,
  output logic              start_clr
);

  logic trig_lvl;
  logic trig_rise;
  logic flag_eff;

  cqs_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (trig_in),
    .level_o  (trig_lvl),
    .rise_o   (trig_rise)
  );

  cqs_start_guard u_guard (
    .clk        (clk),
    .rst        (rst),
    .start_flag (start_flag),
    .clr_pulse  (start_clr),
    .flag_eff   (flag_eff)
  );

  cqs_status_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .flag_eff  (flag_eff),
    .trig_lvl  (trig_lvl),
    .trig_rise (trig_rise),
    .pause_req (pause_req),
    .last_done (last_done),
    .status    (status),
    .triggered (triggered),
    .start_clr (start_clr)
  );

endmodule

// File: rtl/cqs_checker.sv
module cqs_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic       pause_req,
  input logic       last_done,
  input logic [1:0] status,
  input logic       triggered,
  input logic       start_clr
);

  assert_no_reserved_R1: assert property (@(posedge clk) disable iff (rst)
    status != 2'b01);

  assert_off_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0 || mode >= 3'd6) |=> status == 2'b00);

  assert_single_no_skip_R3: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b00 && (mode == 3'd2 || mode == 3'd3) && mode == $past(mode))
      |=> status != 2'b11);

  assert_pause_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b11 && pause_req && !last_done && mode == $past(mode))
      |=> status == 2'b10);

  assert_single_end_R9: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b11 && last_done && mode >= 3'd1 && mode <= 3'd3 && mode == $past(mode))
      |=> (status == 2'b00 && start_clr));

  assert_clr_idle_R9: assert property (@(posedge clk) disable iff (rst)
    start_clr |-> status == 2'b00);

  assert_clr_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    start_clr |=> !start_clr);

  assert_cont_edge_end_R10: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b11 && last_done && mode == 3'd4 && mode == $past(mode))
      |=> status == 2'b10);

  assert_trig_match_R12: assert property (@(posedge clk) disable iff (rst)
    triggered == (status == 2'b11));

endmodule

bind cq_scan_status cqs_checker u_cqs_checker (
  .clk       (clk),
  .rst       (rst),
  .mode      (mode),
  .pause_req (pause_req),
  .last_done (last_done),
  .status    (status),
  .triggered (triggered),
  .start_clr (start_clr)
);

// File: tb/tb_cq_scan_status.sv
`timescale 1ns/1ps
module tb_cq_scan_status;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       start_flag = 1'b0;
  logic       trig_in = 1'b0;
  logic       pause_req = 1'b0;
  logic       last_done = 1'b0;
  logic [1:0] status;
  logic       triggered;
  logic       start_clr;

  int    checks = 0;
  int    fails  = 0;
  string cur    = "R2";
  bit    finished = 1'b0;

  always #5 clk = ~clk;

  cq_scan_status dut (
    .clk(clk), .rst(rst), .mode(mode), .start_flag(start_flag),
    .trig_in(trig_in), .pause_req(pause_req), .last_done(last_done),
    .status(status), .triggered(triggered), .start_clr(start_clr)
  );

  // Behavioural reference model
  logic [1:0] m_st;
  logic       m_trg, m_clr, m_pend, s1, s2, s2d;
  logic [2:0] m_prev;

  function automatic logic [2:0] model_next(input logic [2:0] md, input logic [2:0] pv,
      input logic [1:0] st, input logic feff, input logic lvl, input logic rise,
      input logic pz, input logic ld);
    bit off, sgl, sw, edg, lv;
    off = (md == 0) || (md >= 6);
    sgl = (md >= 1) && (md <= 3);
    sw  = (md == 1);
    edg = (md == 2) || (md == 4);
    lv  = (md == 3) || (md == 5);
    if (off) return 3'b000;
    if (md != pv) begin
      if (sgl && !sw) return feff ? 3'b010 : 3'b000;
      return 3'b010;
    end
    if (st == 2'b00) begin
      if (sgl && feff) return (sw && !pz) ? 3'b011 : 3'b010;
      return 3'b000;
    end
    if (st == 2'b10) begin
      if (!pz && ((sw && feff) || (edg && rise) || (lv && lvl))) return 3'b011;
      return 3'b010;
    end
    if (ld && sgl) return 3'b100;
    if (ld && edg) return 3'b010;
    if (pz) return 3'b010;
    if (lv && !lvl) return 3'b010;
    return 3'b011;
  endfunction

  logic [2:0] m_nx;
  logic       m_feff;
  always @(posedge clk) begin
    if (rst) begin
      m_st <= 2'b00; m_trg <= 1'b0; m_clr <= 1'b0; m_pend <= 1'b0;
      m_prev <= 3'd0; s1 <= 1'b0; s2 <= 1'b0; s2d <= 1'b0;
    end else begin
      m_feff = start_flag && !m_pend && !m_clr;
      m_nx = model_next(mode, m_prev, m_st, m_feff, s2, s2 && !s2d, pause_req, last_done);
      s1 <= trig_in; s2 <= s1; s2d <= s2;
      m_pend <= m_clr ? 1'b1 : (start_flag ? m_pend : 1'b0);
      m_st  <= {m_nx[1], m_nx[0]} == 2'b00 ? 2'b00 : m_nx[1:0];
      m_trg <= (m_nx[1:0] == 2'b11);
      m_clr <= m_nx[2];
      m_prev <= mode;
    end
  end

  task automatic compare_all();
    checks++;
    if (status === 2'b01) begin
      fails++; $display("FAIL R1 status=%b expected=not 01", status);
    end
    checks++;
    if (triggered !== (status == 2'b11)) begin
      fails++; $display("FAIL R12 triggered=%b expected=%b", triggered, status == 2'b11);
    end
    checks++;
    if (status !== m_st || triggered !== m_trg || start_clr !== m_clr) begin
      fails++;
      $display("FAIL %s st/trg/clr=%b/%b/%b expected=%b/%b/%b", cur,
               status, triggered, start_clr, m_st, m_trg, m_clr);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expect_st(string tag, logic [1:0] e);
    checks++;
    if (status !== e) begin
      fails++; $display("FAIL %s status=%b expected=%b", tag, status, e);
    end
  endtask

  task automatic expect_clr(string tag, logic e);
    checks++;
    if (start_clr !== e) begin
      fails++; $display("FAIL %s start_clr=%b expected=%b", tag, start_clr, e);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R2: reset state
    run(3);
    expect_st("R2 reset", 2'b00);
    expect_clr("R2 reset", 1'b0);
    rst = 1'b0;
    run(2);

    // R3: single-scan edge mode
    cur = "R3"; mode = 3'd2;
    run(4);
    expect_st("R3 idle without start", 2'b00);
    start_flag = 1'b1;
    tick();
    expect_st("R3 start arms", 2'b10);

    // R6: trigger latency of three edges
    cur = "R6"; trig_in = 1'b1;
    tick(); tick();
    expect_st("R6 not yet triggered", 2'b10);
    tick();
    expect_st("R6 triggered third edge", 2'b11);
    run(3);
    expect_st("R6 held high", 2'b11);

    // R9: end of single scan
    cur = "R9"; last_done = 1'b1;
    tick();
    last_done = 1'b0;
    expect_st("R9 end to idle", 2'b00);
    expect_clr("R9 clear pulse", 1'b1);
    tick();
    expect_clr("R9 pulse one cycle", 1'b0);
    run(3);
    expect_st("R9 flag ignored until low", 2'b00);
    start_flag = 1'b0;
    run(2);
    start_flag = 1'b1;
    tick();
    expect_st("R9 rearm after low", 2'b10);
    run(3);
    expect_st("R6 held input no retrigger", 2'b10);
    trig_in = 1'b0;
    run(3);

    // R7: single-scan level mode, entered with flag high
    cur = "R7"; mode = 3'd3;
    tick();
    expect_st("R3 entry with flag", 2'b10);
    trig_in = 1'b1;
    run(3);
    expect_st("R7 level high", 2'b11);
    trig_in = 1'b0;
    run(3);
    expect_st("R7 level low", 2'b10);
    trig_in = 1'b1;
    run(3);
    cur = "R8"; pause_req = 1'b1;
    tick();
    expect_st("R8 pause drops", 2'b10);
    run(3);
    expect_st("R8 pause blocks", 2'b10);
    pause_req = 1'b0;
    tick();
    expect_st("R8 release retriggers", 2'b11);
    last_done = 1'b1;
    tick();
    last_done = 1'b0;
    trig_in = 1'b0;
    expect_st("R9 level single end", 2'b00);
    start_flag = 1'b0;
    run(3);

    // R4: single-scan software mode
    cur = "R4"; mode = 3'd1;
    tick();
    expect_st("R4 entry waits", 2'b10);
    start_flag = 1'b1;
    tick();
    expect_st("R4 flag triggers", 2'b11);
    cur = "R11"; pause_req = 1'b1; last_done = 1'b1;
    tick();
    pause_req = 1'b0; last_done = 1'b0;
    expect_st("R11 end over pause", 2'b00);
    start_flag = 1'b0;
    run(3);
    cur = "R4"; pause_req = 1'b1; start_flag = 1'b1;
    tick();
    expect_st("R4 flag with pause from idle", 2'b10);
    pause_req = 1'b0;
    tick();
    expect_st("R4 trigger after pause", 2'b11);
    start_flag = 1'b0;

    // R5 and R10: continuous edge mode
    cur = "R5"; mode = 3'd4;
    tick();
    expect_st("R5 continuous entry", 2'b10);
    cur = "R10"; trig_in = 1'b1;
    run(3);
    expect_st("R6 continuous edge", 2'b11);
    last_done = 1'b1;
    tick();
    last_done = 1'b0;
    expect_st("R10 edge end to waiting", 2'b10);
    run(3);
    expect_st("R6 no retrigger held", 2'b10);
    trig_in = 1'b0;
    run(2);
    trig_in = 1'b1;
    run(3);
    expect_st("R6 new edge", 2'b11);

    // R10: continuous level mode
    cur = "R10"; mode = 3'd5;
    tick();
    expect_st("R5 level entry", 2'b10);
    tick();
    expect_st("R7 level triggers", 2'b11);
    last_done = 1'b1;
    tick();
    last_done = 1'b0;
    expect_st("R10 level end no effect", 2'b11);

    // R11: mode change wins over end of queue
    cur = "R11"; mode = 3'd4; last_done = 1'b1;
    tick();
    last_done = 1'b0;
    expect_st("R11 mode change priority", 2'b10);
    cur = "R2"; mode = 3'd0;
    tick();
    expect_st("R2 off idle", 2'b00);
    mode = 3'd5;
    run(3);
    mode = 3'd6;
    tick();
    expect_st("R2 code 6 as off", 2'b00);
    trig_in = 1'b0;

    // R8: pause has no effect on idle
    cur = "R8"; mode = 3'd2; start_flag = 1'b0; pause_req = 1'b1;
    run(3);
    expect_st("R8 idle unaffected", 2'b00);
    pause_req = 1'b0;

    // Mixed stimulus against the model
    cur = "R11";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(39) == 0) mode = 3'($urandom_range(7));
      if ($urandom_range(9) == 0) start_flag = ~start_flag;
      if ($urandom_range(5) == 0) trig_in = ~trig_in;
      pause_req = ($urandom_range(9) == 0);
      last_done = ($urandom_range(7) == 0);
      tick();
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule